// File: doc/BRIEF.md
# Extended-Range Step Interval Scheduler

This block produces two timing streams from one free-running 16-bit counter. The first is a periodic system tick. The second is a step pulse that fires after a requested delay. That delay is a 32-bit cycle count. A 16-bit comparator alone could not reach it, so the step channel keeps a 32-bit remainder that survives counter wraps. The channel only commits to a real step match once the remainder fits in one wrap.

Each delay is measured from the previous step compare point, not from the moment the request arrives. Back-to-back steps therefore stay evenly spaced even when the requester answers late. Delays that end just past a wrap get special handling. The compare point is pulled 10000 cycles early and the same amount is added to the remainder, so the intermediate wrap match and the real step match never land close together.

A requester that sets the check-short flag is told when its request is already too late to schedule safely. A stop input silences both channels.

Top module: `step_interval_sched`

## Requirements
- R1: After reset, step_o, tick_o and too_short_o are low. The counter holds 0 in the first cycle after reset and then counts up by one each cycle, modulo 65536. The step reference starts at 0.
- R2: tick_o is high for exactly one cycle in the cycle after the counter equals k*TICK_TIME modulo 65536, for k = 1, 2, .... Counted from reset release, ticks appear in cycles k*TICK_TIME+1.
- R3: An accepted request with delay below 65536 produces step_o in the cycle after the counter reaches (reference + delay) modulo 65536. The reference is the counter value of the previous step compare match, not the cycle of the request.
- R4: step_o is high for one cycle only. The step channel then stays idle until the next accepted request.
- R5: A delay from 65536 to 75535 first places the compare 10000 cycles before the reference and adds 10000 to the remainder. The only step pulse comes reference + delay cycles after the reference; the intermediate match gives none.
- R6: A delay of 75536 or more keeps the compare at the reference for a full wrap. The remainder is then reduced by 65536 on each match, and the step pulse comes reference + delay cycles after the reference.
- R7: With check_short_i high, a request is rejected when ((counter − reference) mod 65536) + 200 > delay, with delay read as signed. too_short_o is then high in the following cycle, and neither the compare, the remainder nor the armed state changes.
- R8: With check_short_i high, every delay of zero or below is rejected.
- R9: With check_short_i low, a request is always armed and too_short_o stays low. The delay bits are read as an unsigned count.
- R10: A request in the same cycle as a step match takes precedence. That match gives no pulse, and the new delay is measured from the matched compare value.
- R11: stop_i disables both channels from the next cycle. It also beats a request in the same cycle. Ticks stay off until reset; steps stay off until a later request.
- R12: When a step match and a tick match fall in the same cycle, step_o and tick_o pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| set_i | input | 1 | Request strobe: schedule the next step |
| delay_i | input | 32 | Delay in cycles from the previous step compare point (signed when checked) |
| check_short_i | input | 1 | Reject requests that are too late to schedule |
| stop_i | input | 1 | Disable both channels |
| step_o | output | 1 | One-cycle step pulse |
| tick_o | output | 1 | One-cycle periodic tick pulse |
| too_short_o | output | 1 | One-cycle rejection flag for a request |

## Verification
Each output goes through exactly one register. A step or tick pulse therefore appears one cycle after the counter shows the compare value, too_short_o appears one cycle after the request, and the effect of stop_i shows one cycle after it is asserted.

The bench keeps its own count of clock edges since reset release, which equals the internal counter. From that count it computes the absolute cycle of every expected pulse as reference + delay + 1. It drives and samples on the falling edge and records the first step pulse inside a window around the expected cycle, so an early wrap match or a late fire is reported with both cycle numbers. Rejection and collision results are read on the falling edge directly after the request edge.

// File: rtl/sts_pkg.sv
package sts_pkg;

    // How a pending remainder is mapped onto the 16-bit comparator.
    typedef enum logic [1:0] {
        RNG_DIRECT = 2'd0,   // fits in one wrap: compare at start + remainder
        RNG_EARLY  = 2'd1,   // just past one wrap: fire early, grow remainder
        RNG_WRAP   = 2'd2    // far away: wait one full wrap at start
    } rng_e;

endpackage

// File: rtl/sts_free_counter.sv
module sts_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sts_range_plan.sv
module sts_range_plan
    import sts_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DLY_W     = 32,
    parameter int EARLY_WIN = 10000
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [DLY_W-1:0] rem_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic [DLY_W-1:0] rem_o
);
    localparam logic [DLY_W-1:0] WRAP_V  = DLY_W'(64'd1 << CNT_W);
    localparam logic [DLY_W-1:0] EARLY_V = DLY_W'(EARLY_WIN);
    localparam logic [DLY_W-1:0] MID_V   = WRAP_V + EARLY_V;

    rng_e sel;

    always_comb begin
        if (rem_i < WRAP_V)     sel = RNG_DIRECT;
        else if (rem_i < MID_V) sel = RNG_EARLY;
        else                    sel = RNG_WRAP;
    end

    always_comb begin
        cmp_o = start_i;
        rem_o = rem_i;
        case (sel)
            RNG_DIRECT: cmp_o = start_i + rem_i[CNT_W-1:0];
            RNG_EARLY: begin
                cmp_o = start_i - CNT_W'(EARLY_WIN);
                rem_o = rem_i + EARLY_V;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sts_tick_chan.sv
module sts_tick_chan #(
    parameter int CNT_W     = 16,
    parameter int TICK_TIME = 1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             stop_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             en;
        logic             pulse;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (stop_i) begin
            st_d.en = 1'b0;
        end else if (st_q.en && (cnt_i == st_q.cmp)) begin
            st_d.pulse = 1'b1;
            st_d.cmp   = st_q.cmp + CNT_W'(TICK_TIME);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cmp   <= CNT_W'(TICK_TIME);
            st_q.en    <= 1'b1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.pulse;
endmodule

// File: rtl/sts_step_chan.sv
module sts_step_chan #(
    parameter int CNT_W       = 16,
    parameter int DLY_W       = 32,
    parameter int EARLY_WIN   = 10000,
    parameter int SHORT_GUARD = 200
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             set_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             check_short_i,
    input  logic             stop_i,
    output logic             step_o,
    output logic             too_short_o
);
    localparam logic [DLY_W-1:0] WRAP_V = DLY_W'(64'd1 << CNT_W);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic [DLY_W-1:0] rem;
        logic             armed;
        logic             step;
        logic             short_flag;
    } step_st_t;

    step_st_t st_d, st_q;

    logic [CNT_W-1:0]        set_cmp, run_cmp, elapsed;
    logic [DLY_W-1:0]        set_rem, run_rem;
    logic signed [DLY_W:0]   need_s, delay_s;
    logic                    hit, too_short;

    // New request: start from the last compare point.
    sts_range_plan #(.CNT_W(CNT_W), .DLY_W(DLY_W), .EARLY_WIN(EARLY_WIN)) i_plan_set (
        .start_i (st_q.cmp),
        .rem_i   (delay_i),
        .cmp_o   (set_cmp),
        .rem_o   (set_rem)
    );

    // Wrap match: one full counter period consumed.
    sts_range_plan #(.CNT_W(CNT_W), .DLY_W(DLY_W), .EARLY_WIN(EARLY_WIN)) i_plan_run (
        .start_i (st_q.cmp),
        .rem_i   (st_q.rem - WRAP_V),
        .cmp_o   (run_cmp),
        .rem_o   (run_rem)
    );

    always_comb begin
        elapsed   = cnt_i - st_q.cmp;
        need_s    = $signed({{(DLY_W + 1 - CNT_W){1'b0}}, elapsed}) + $signed((DLY_W + 1)'(SHORT_GUARD));
        delay_s   = $signed({delay_i[DLY_W-1], delay_i});
        too_short = check_short_i && (need_s > delay_s);
        hit       = st_q.armed && (cnt_i == st_q.cmp);
    end

    always_comb begin
        st_d            = st_q;
        st_d.step       = 1'b0;
        st_d.short_flag = 1'b0;
        if (stop_i) begin
            st_d.armed = 1'b0;
        end else if (set_i) begin
            if (too_short) begin
                st_d.short_flag = 1'b1;
            end else begin
                st_d.cmp   = set_cmp;
                st_d.rem   = set_rem;
                st_d.armed = 1'b1;
            end
        end else if (hit) begin
            if (st_q.rem < WRAP_V) begin
                st_d.step  = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cmp = run_cmp;
                st_d.rem = run_rem;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o      = st_q.step;
    assign too_short_o = st_q.short_flag;
endmodule

// File: rtl/step_interval_sched.sv
module step_interval_sched #(
    parameter int CNT_W       = 16,
    parameter int DLY_W       = 32,
    parameter int TICK_TIME   = 1000,
    parameter int EARLY_WIN   = 10000,
    parameter int SHORT_GUARD = 200
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             check_short_i,
    input  logic             stop_i,
    output logic             step_o,
    output logic             tick_o,
    output logic             too_short_o
);
    logic [CNT_W-1:0] cnt;

    sts_free_counter #(.CNT_W(CNT_W)) i_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt)
    );

    sts_tick_chan #(.CNT_W(CNT_W), .TICK_TIME(TICK_TIME)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_i  (cnt),
        .stop_i (stop_i),
        .tick_o (tick_o)
    );

    sts_step_chan #(
        .CNT_W       (CNT_W),
        .DLY_W       (DLY_W),
        .EARLY_WIN   (EARLY_WIN),
        .SHORT_GUARD (SHORT_GUARD)
    ) i_step (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cnt_i         (cnt),
        .set_i         (set_i),
        .delay_i       (delay_i),
        .check_short_i (check_short_i),
        .stop_i        (stop_i),
        .step_o        (step_o),
        .too_short_o   (too_short_o)
    );
endmodule

// File: rtl/sts_checker.sv
module sts_checker #(
    parameter int DLY_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             set_i,
    input logic [DLY_W-1:0] delay_i,
    input logic             check_short_i,
    input logic             stop_i,
    input logic             step_o,
    input logic             tick_o,
    input logic             too_short_o
);
    // R4
    step_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);

    // R2
    tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R11
    stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!step_o && !tick_o && !too_short_o));

    // R7
    short_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        too_short_o |-> $past(set_i && check_short_i && !stop_i));

    // R8
    nonpos_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && check_short_i && !stop_i && ($signed(delay_i) <= 0)) |=> too_short_o);

    // R9
    unchecked_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !check_short_i) |=> !too_short_o);

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> !step_o);
endmodule

bind step_interval_sched sts_checker #(.DLY_W(DLY_W)) i_sts_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_i         (set_i),
    .delay_i       (delay_i),
    .check_short_i (check_short_i),
    .stop_i        (stop_i),
    .step_o        (step_o),
    .tick_o        (tick_o),
    .too_short_o   (too_short_o)
);

// File: tb/test_step_interval_sched.sv
module test_step_interval_sched;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TICK       = 1000;
    localparam int  WATCHDOG   = 180000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        set_i = 1'b0;
    logic [31:0] delay_i = '0;
    logic        check_short_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        step_o, tick_o, too_short_o;

    int     n_tests = 0;
    int     n_fail  = 0;
    longint cyc     = 0;
    int     tick_count = 0;
    int     tick_bad   = 0;
    bit     done = 1'b0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    step_interval_sched #(.TICK_TIME(TICK)) i_step_interval_sched (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .set_i         (set_i),
        .delay_i       (delay_i),
        .check_short_i (check_short_i),
        .stop_i        (stop_i),
        .step_o        (step_o),
        .tick_o        (tick_o),
        .too_short_o   (too_short_o)
    );

    // Mirror of the free-running counter (unwrapped).
    always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

    // Tick monitor for R2: ticks only in cycles k*TICK+1.
    always @(negedge clk_i) begin
        if (rst_ni && tick_o) begin
            tick_count++;
            if (((cyc - 1) % TICK) != 0) tick_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_set(input int d, input bit cs, output bit ts, output bit st);
        set_i = 1'b1; delay_i = d; check_short_i = cs;
        @(negedge clk_i);
        set_i = 1'b0; check_short_i = 1'b0;
        ts = too_short_o;
        st = step_o;
    endtask

    task automatic wait_step(input longint exp_abs, input string req, output bit tick_at);
        longint got = -1;
        tick_at = 1'b0;
        while (cyc < exp_abs + 40) begin
            @(negedge clk_i);
            if (step_o) begin
                got = cyc;
                tick_at = tick_o;
                break;
            end
        end
        chk(got == exp_abs + 1, req, "step cycle", got, exp_abs + 1);
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk_i);
    endtask

    task automatic t_reset();
        chk(step_o == 1'b0, "R1", "step_o after reset", step_o, 0);
        chk(tick_o == 1'b0, "R1", "tick_o after reset", tick_o, 0);
        chk(too_short_o == 1'b0, "R1", "too_short_o after reset", too_short_o, 0);
    endtask

    task automatic t_first_step();
        bit ts, st, tk;
        wait_until(10);
        do_set(1000, 1'b1, ts, st);
        chk(ts == 1'b0, "R3", "accepted request flagged", ts, 0);
        wait_step(1000, "R3", tk);
        chk(tk == 1'b1, "R12", "tick with coincident step", tk, 1);
    endtask

    task automatic t_chain();
        bit ts, st, tk;
        @(negedge clk_i);
        chk(step_o == 1'b0, "R4", "step_o second cycle", step_o, 0);
        do_set(300, 1'b1, ts, st);
        chk(ts == 1'b0, "R3", "chained request flagged", ts, 0);
        wait_step(1300, "R3", tk);
    endtask

    task automatic t_short();
        bit ts, st;
        int seen = 0;
        @(negedge clk_i);
        do_set(150, 1'b1, ts, st);
        chk(ts == 1'b1, "R7", "late request not rejected", ts, 1);
        do_set(-5, 1'b1, ts, st);
        chk(ts == 1'b1, "R8", "negative delay not rejected", ts, 1);
        do_set(0, 1'b1, ts, st);
        chk(ts == 1'b1, "R8", "zero delay not rejected", ts, 1);
        repeat (300) begin
            @(negedge clk_i);
            if (step_o) seen++;
        end
        chk(seen == 0, "R7", "step after rejected requests", seen, 0);
    endtask

    task automatic t_mid();
        bit ts, st, tk;
        wait_until(1700);
        do_set(66000, 1'b1, ts, st);
        chk(ts == 1'b0, "R5", "mid-range request flagged", ts, 0);
        wait_step(1300 + 66000, "R5", tk);
    endtask

    task automatic t_long();
        bit ts, st, tk;
        do_set(76000, 1'b1, ts, st);
        chk(ts == 1'b0, "R6", "long request flagged", ts, 0);
        wait_step(67300 + 76000, "R6", tk);
    endtask

    task automatic t_collide();
        bit ts, st, tk;
        do_set(400, 1'b0, ts, st);
        chk(ts == 1'b0, "R9", "unchecked request flagged", ts, 0);
        wait_until(143700);
        do_set(100, 1'b0, ts, st);
        chk(st == 1'b0, "R10", "pulse from overridden match", st, 0);
        wait_step(143800, "R10", tk);
    endtask

    task automatic t_stop();
        bit ts, st;
        int steps = 0;
        int ticks_before;
        do_set(1000, 1'b0, ts, st);
        wait_until(143850);
        chk(tick_count == int'((cyc - 1) / TICK), "R2", "tick count", tick_count, (cyc - 1) / TICK);
        chk(tick_bad == 0, "R2", "misplaced ticks", tick_bad, 0);
        ticks_before = tick_count;
        stop_i = 1'b1;
        do_set(200, 1'b0, ts, st);
        stop_i = 1'b0;
        chk(ts == 1'b0, "R11", "flag during stop", ts, 0);
        repeat (3000) begin
            @(negedge clk_i);
            if (step_o) steps++;
        end
        chk(steps == 0, "R11", "steps after stop", steps, 0);
        chk(tick_count == ticks_before, "R11", "ticks after stop", tick_count, ticks_before);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_first_step();
        t_chain();
        t_short();
        t_mid();
        t_long();
        t_collide();
        t_stop();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk_i);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule